// File: doc/BRIEF.md
# Bit Test and Modify Unit

This unit executes the four single-bit operations on a 32-bit operand: test, test-and-set, test-and-reset and test-and-complement. The operand sits either in a register, whose value comes in on a port, or in memory, reached through a simple request/ready port. Every operation returns the selected bit's original value as the carry flag. The three modifying forms also return the updated dword. For a register operand it goes to a register write port. For a memory operand it is written back to the address just read.

The bit index comes from one of two places: a full-width register value or an 8-bit immediate. The bit position inside the dword is always the index's low five bits. There is one special case. When a memory operand uses a register index, the bits above those five form a signed dword displacement. Four times that displacement is added to the effective address, so a bit string can extend in either direction from the base. The final address is ANDed with an address-size mask, and addresses therefore wrap under a 16-bit mask. A small sequencer runs the memory accesses and pulses `done` when the operation is finished.

Top module: `bit_test_unit`

## Requirements
- R1: The bit position is the low five bits of the selected index source: `imm_idx[4:0]` when `idx_imm`=1, otherwise `idx_reg[4:0]`. All higher index bits have no effect on which bit is chosen.
- R2: `cf`, valid while `done`=1, equals the selected bit of the operand as it was before any modification.
- R3: Reset state: `busy`, `done`, `mem_req` and `reg_we` are all low. With `is_mem`=0, `done` rises one cycle after `start` and lasts exactly one cycle. After that the unit is idle.
- R4: Opcode encoding is 0 test, 1 set, 2 reset, 3 complement. Test (op 0) never asserts `reg_we` and never issues a memory write. On a memory operand it performs exactly one read.
- R5: With `is_mem`=1 and `idx_imm`=0, the access address is (`eff_addr` + 4 × (signed `idx_reg` arithmetically shifted right by 5)) AND `addr_mask`. Negative indices move the address downward.
- R6: With `is_mem`=1 and `idx_imm`=1, the access address is `eff_addr` AND `addr_mask`, and `idx_reg` has no effect.
- R7: A modifying memory operation issues a read (`mem_we`=0) and then a write (`mem_we`=1) to the same address. The written data is the read data with the selected bit set (op 1), cleared (op 2) or inverted (op 3).
- R8: A memory request holds `mem_req`, `mem_addr` and `mem_we` steady until a cycle with `mem_ready`=1 completes it. `done` follows only after the last access has completed.
- R9: A register operation with op 1–3 drives `reg_we`=1 during its `done` cycle, with `reg_wdata` set to the modified register value. `start` is ignored while `busy`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 2 | 0 test, 1 set, 2 reset, 3 complement |
| is_mem | input | 1 | 1: operand in memory, 0: operand is `reg_val` |
| idx_imm | input | 1 | 1: index from `imm_idx`, 0: from `idx_reg` |
| reg_val | input | 32 | Register operand value |
| idx_reg | input | 32 | Register-supplied bit index |
| imm_idx | input | 8 | Immediate bit index |
| eff_addr | input | 32 | Effective byte address of the memory operand |
| addr_mask | input | 32 | Address-size mask applied to the final address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cf | output | 1 | Original value of the selected bit, valid with `done` |
| reg_we | output | 1 | Register write enable for modifying register forms |
| reg_wdata | output | 32 | Modified register value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Memory dword address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Completes the current access |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |

## Verification
Some properties hold on every cycle, and assertions check them continuously. A memory request stays stable while it waits for ready, and a test never issues a write. The write of a read-modify-write uses the address of its read. `done` is a single-cycle pulse, and a register write can only appear in a register-form `done` cycle. The ALU changes at most one bit, and none at all for a test. The bench's scenarios cover what the assertions cannot see: the address arithmetic, meaning signed displacements across several dwords, negative offsets and wrap under a 16-bit mask. The scenarios also show that the carry is taken before modification, that the memory image and write data are correct after each operation, that the immediate and upper index bits are ignored, and that a `start` arriving mid-operation is dropped.

// File: rtl/bt_pkg.sv
package bt_pkg;
   typedef enum logic [1:0] {
      BT_OP_TEST = 2'd0,
      BT_OP_SET  = 2'd1,
      BT_OP_CLR  = 2'd2,
      BT_OP_FLIP = 2'd3
   } bt_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2,
      ST_DONE  = 2'd3
   } bt_state_e;
endpackage

// File: rtl/bt_index_decode.sv
module bt_index_decode #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   parameter int IMM_W  = 8,
   localparam int POS_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] idx_reg,
   input  logic [IMM_W-1:0]  imm_idx,
   input  logic              idx_imm,
   input  logic [ADDR_W-1:0] eff_addr,
   input  logic [ADDR_W-1:0] addr_mask,
   output logic [POS_W-1:0]  pos,
   output logic [ADDR_W-1:0] addr
);
   localparam int BYTE_SH = $clog2(DATA_W / 8);
   localparam int EXT_W   = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;

   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("bt_index_decode: DATA_W must be a power of two of at least 8");
   end
   if (IMM_W < POS_W) begin : g_bad_imm
      $error("bt_index_decode: IMM_W too narrow for a bit position");
   end

   logic signed [EXT_W-1:0] idx_ext;
   logic signed [EXT_W-1:0] disp;
   logic        [EXT_W-1:0] scaled;
   logic        [ADDR_W-1:0] offset;
   logic                    unused_imm_hi;

   assign idx_ext = EXT_W'(signed'(idx_reg));
   assign disp    = idx_ext >>> POS_W;
   assign scaled  = disp << BYTE_SH;
   assign offset  = ADDR_W'(scaled);

   assign pos  = idx_imm ? imm_idx[POS_W-1:0] : idx_reg[POS_W-1:0];
   assign addr = (idx_imm ? eff_addr : (eff_addr + offset)) & addr_mask;

   if (IMM_W > POS_W) begin : g_imm_sink
      assign unused_imm_hi = ^imm_idx[IMM_W-1:POS_W];
   end else begin : g_imm_nosink
      assign unused_imm_hi = 1'b0;
   end
endmodule

// File: rtl/bt_bit_alu.sv
module bt_bit_alu
   import bt_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int POS_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] din,
   input  logic [POS_W-1:0]  pos,
   input  bt_op_e            op,
   output logic              cf,
   output logic [DATA_W-1:0] dout
);
   assign cf = din[pos];

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic hit;
      assign hit = (pos == POS_W'(i));
      assign dout[i] = !hit             ? din[i]  :
                       (op == BT_OP_SET)  ? 1'b1    :
                       (op == BT_OP_CLR)  ? 1'b0    :
                       (op == BT_OP_FLIP) ? ~din[i] : din[i];
   end

   always_comb begin
      AST_ALU_ONE_BIT: assert ($countones(din ^ dout) <= 1);          // R7
      AST_ALU_TEST_KEEPS: assert (op != BT_OP_TEST || dout == din);   // R4
   end
endmodule

// File: rtl/bt_seq.sv
module bt_seq
   import bt_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   localparam int POS_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic              is_mem,
   input  logic [DATA_W-1:0] reg_val,
   input  logic [POS_W-1:0]  pos_in,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata,
   output bt_op_e            op_q,
   output logic [POS_W-1:0]  pos_q,
   output logic [DATA_W-1:0] opnd_q,
   output logic              mem_q,
   output logic              busy,
   output logic              done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr
);
   bt_state_e state;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         op_q   <= BT_OP_TEST;
         pos_q  <= '0;
         opnd_q <= '0;
         mem_q  <= 1'b0;
         addr_q <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               op_q   <= bt_op_e'(op);
               pos_q  <= pos_in;
               addr_q <= addr_in;
               mem_q  <= is_mem;
               opnd_q <= reg_val;
               state  <= is_mem ? ST_READ : ST_DONE;
            end
            ST_READ: if (mem_ready) begin
               opnd_q <= mem_rdata;
               state  <= (op_q == BT_OP_TEST) ? ST_DONE : ST_WRITE;
            end
            ST_WRITE: if (mem_ready) state <= ST_DONE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state != ST_IDLE);
   assign done     = (state == ST_DONE);
   assign mem_req  = (state == ST_READ) || (state == ST_WRITE);
   assign mem_we   = (state == ST_WRITE);
   assign mem_addr = addr_q;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));  // R8
   AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (op_q != BT_OP_TEST));                                                 // R4
   AST_WRITE_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && $rose(mem_we)) |-> $stable(mem_addr));                                // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                                  // R3
   AST_DONE_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req);                                                               // R8
endmodule

// File: rtl/bit_test_unit.sv
module bit_test_unit
   import bt_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   parameter int IMM_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic              is_mem,
   input  logic              idx_imm,
   input  logic [DATA_W-1:0] reg_val,
   input  logic [DATA_W-1:0] idx_reg,
   input  logic [IMM_W-1:0]  imm_idx,
   input  logic [ADDR_W-1:0] eff_addr,
   input  logic [ADDR_W-1:0] addr_mask,
   output logic              busy,
   output logic              done,
   output logic              cf,
   output logic              reg_we,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int POS_W = $clog2(DATA_W);

   logic [POS_W-1:0]  pos_d, pos_q;
   logic [ADDR_W-1:0] addr_d;
   logic [DATA_W-1:0] opnd_q, alu_out;
   bt_op_e            op_q;
   logic              mem_q;

   bt_index_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_dec (
      .idx_reg   (idx_reg),
      .imm_idx   (imm_idx),
      .idx_imm   (idx_imm),
      .eff_addr  (eff_addr),
      .addr_mask (addr_mask),
      .pos       (pos_d),
      .addr      (addr_d)
   );

   bt_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .op        (op),
      .is_mem    (is_mem),
      .reg_val   (reg_val),
      .pos_in    (pos_d),
      .addr_in   (addr_d),
      .mem_ready (mem_ready),
      .mem_rdata (mem_rdata),
      .op_q      (op_q),
      .pos_q     (pos_q),
      .opnd_q    (opnd_q),
      .mem_q     (mem_q),
      .busy      (busy),
      .done      (done),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr)
   );

   bt_bit_alu #(.DATA_W(DATA_W)) u_alu (
      .din  (opnd_q),
      .pos  (pos_q),
      .op   (op_q),
      .cf   (cf),
      .dout (alu_out)
   );

   assign reg_we    = done && !mem_q && (op_q != BT_OP_TEST);
   assign reg_wdata = alu_out;
   assign mem_wdata = alu_out;

   AST_REG_WE_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (done && !mem_req));                                                  // R9
endmodule

// File: tb/tb_bit_test_unit.sv
`timescale 1ns/1ps
module tb_bit_test_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'd0;
   logic        is_mem = 1'b0, idx_imm = 1'b0;
   logic [31:0] reg_val = '0, idx_reg = '0, eff_addr = '0, addr_mask = '1;
   logic [7:0]  imm_idx = '0;
   logic        busy, done, cf, reg_we, mem_req, mem_we;
   logic [31:0] reg_wdata, mem_addr, mem_wdata;
   logic        mem_ready = 1'b0;
   logic [31:0] mem_rdata = '0;

   int checks = 0, errors = 0;
   bit finished = 0;
   int lat = 0, wcnt = 0;
   logic [31:0] mem_arr [0:255];
   logic [31:0] acc_a[$], acc_d[$];
   bit          acc_w[$];

   always #2.5 clk = ~clk;

   bit_test_unit dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .is_mem(is_mem),
      .idx_imm(idx_imm), .reg_val(reg_val), .idx_reg(idx_reg), .imm_idx(imm_idx),
      .eff_addr(eff_addr), .addr_mask(addr_mask), .busy(busy), .done(done),
      .cf(cf), .reg_we(reg_we), .reg_wdata(reg_wdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ready(mem_ready), .mem_rdata(mem_rdata));

   // behavioural memory: grants after lat waiting cycles, commits at grant
   always @(negedge clk) begin
      mem_ready = 1'b0;
      if (rst_n && mem_req) begin
         if (wcnt >= lat) begin
            mem_ready = 1'b1;
            mem_rdata = mem_arr[mem_addr[9:2]];
            if (mem_we) mem_arr[mem_addr[9:2]] = mem_wdata;
            acc_a.push_back(mem_addr);
            acc_w.push_back(mem_we);
            acc_d.push_back(mem_wdata);
            wcnt = 0;
         end else wcnt++;
      end else wcnt = 0;
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input int opc, input bit m, input bit isel,
                         input logic [31:0] rv, input logic [31:0] ir,
                         input logic [7:0] iv, input logic [31:0] ea,
                         input logic [31:0] am, input int latency, input bit poke);
      logic [4:0]  p;
      logic [31:0] a, old, nw;
      logic signed [31:0] s;
      int d, cyc;
      bit fin, saw_we, saw_bad;
      p = isel ? iv[4:0] : ir[4:0];
      s = ir;
      d = s >>> 5;
      a = (isel ? ea : ea + 32'(d * 4)) & am;
      old = m ? mem_arr[a[9:2]] : rv;
      nw = old;
      case (opc)
         1: nw[p] = 1'b1;
         2: nw[p] = 1'b0;
         3: nw[p] = ~old[p];
         default: ;
      endcase
      lat = latency;
      acc_a.delete(); acc_w.delete(); acc_d.delete();
      op = 2'(opc); is_mem = m; idx_imm = isel; reg_val = rv; idx_reg = ir;
      imm_idx = iv; eff_addr = ea; addr_mask = am; start = 1'b1;
      cyc = 0; fin = 0; saw_we = 0; saw_bad = 0;
      while (!fin) begin
         @(negedge clk);
         cyc++;
         if (cyc == 1) start = 1'b0;
         if (poke && cyc == 2) begin start = 1'b1; op = 2'd1; is_mem = 1'b0; end
         if (poke && cyc == 3) start = 1'b0;
         if (reg_we && (m || opc == 0)) saw_we = 1;
         if (mem_req && mem_we && opc == 0) saw_bad = 1;
         if (done || cyc > 60) fin = 1;
      end
      chk("R8", "done reached", 32'(done), 32'd1);
      chk("R2", "cf old bit", 32'(cf), 32'(old[p]));
      if (!m) begin
         chk("R3", "register latency", cyc, 1);
         chk("R9", "reg_we", 32'(reg_we), 32'(opc != 0));
         if (opc != 0) chk("R9", "reg_wdata", reg_wdata, nw);
      end else begin
         chk("R4", "accesses", acc_a.size(), (opc == 0) ? 1 : 2);
         chk("R4", "no reg_we/no test write", 32'({saw_we, saw_bad}), 32'd0);
         if (acc_a.size() > 0) begin
            chk(isel ? "R6" : "R5", "read address", acc_a[0], a);
            chk("R7", "first is read", 32'(acc_w[0]), 32'd0);
         end
         if (opc != 0 && acc_a.size() > 1) begin
            chk("R7", "write address", acc_a[1], a);
            chk("R7", "second is write", 32'(acc_w[1]), 32'd1);
            chk("R7", "write data", acc_d[1], nw);
         end
         chk("R7", "memory image", mem_arr[a[9:2]], nw);
      end
      @(negedge clk);
      chk("R3", "done pulse ends, idle", 32'({done, busy}), 32'd0);
   endtask

   initial begin
      for (int k = 0; k < 256; k++) mem_arr[k] = (32'h9E3779B9 * k) ^ (k << 8);
      repeat (3) @(negedge clk);
      chk("R3", "reset outputs", 32'({busy, done, mem_req, reg_we}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // register forms: R1 low five bits only
      run_op(0, 0, 1, 32'h0000_0020, 32'h0, 8'hE5, 32'h0, 32'hFFFF_FFFF, 0, 0);
      run_op(1, 0, 0, 32'h0000_0000, 32'hFFFF_FFE7, 8'h0, 32'h0, 32'hFFFF_FFFF, 0, 0);
      run_op(2, 0, 1, 32'hFFFF_FFFF, 32'h0, 8'h1F, 32'h0, 32'hFFFF_FFFF, 0, 0);
      run_op(3, 0, 0, 32'h0000_0001, 32'h0, 8'h0, 32'h0, 32'hFFFF_FFFF, 0, 0);
      // memory, register index: several dwords, negative, wrap (R5)
      run_op(0, 1, 0, 32'h0, 32'd200, 8'h0, 32'h1000, 32'hFFFF_FFFF, 1, 0);
      run_op(1, 1, 0, 32'h0, 32'hFFFF_FFFF, 8'h0, 32'h1000, 32'hFFFF_FFFF, 0, 0);
      run_op(2, 1, 0, 32'h0, 32'hFFFF_FFDF, 8'h0, 32'h1000, 32'hFFFF_FFFF, 2, 1); // R9 poke
      run_op(3, 1, 0, 32'h0, 32'h0000_0100, 8'h0, 32'h0000_FFF0, 32'h0000_FFFF, 1, 0);
      run_op(0, 1, 0, 32'h0, 32'hFFFF_FE00, 8'h0, 32'h0000_0020, 32'h0000_FFFF, 0, 0);
      // memory, immediate index: no displacement (R6)
      run_op(1, 1, 1, 32'h0, 32'h0001_2345, 8'h27, 32'h2040, 32'hFFFF_FFFF, 0, 0);
      run_op(3, 1, 1, 32'h0, 32'h0, 8'h03, 32'h0003_0008, 32'h0000_FFFF, 3, 0);
      run_op(3, 1, 1, 32'h0, 32'h0, 8'h03, 32'h0003_0008, 32'h0000_FFFF, 0, 0);
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule